// File: doc/BRIEF.md
# Four-Function Word ALU with Condition Flags

This block is a stateless arithmetic logic unit for 64-bit words. A 2-bit function selector picks one of four operations on two operand words: sum, difference, bitwise AND or bitwise XOR. The block returns the result word together with three condition flags: signed overflow, zero and carry/borrow.

It has no clock and no storage. The outputs settle from the inputs after gate delay alone. A surrounding pipeline stage registers the result and flags if it needs to keep them.

Sum and difference share one carry-propagate adder. For subtraction, the second operand is inverted and the carry-in is set.

Top module: `word_alu4`

## Requirements
- R1: With `alu_fn` = 2'd0 the result is `alu_x + alu_y` modulo 2^64.
- R2: With `alu_fn` = 2'd1 the result is `alu_x - alu_y` modulo 2^64.
- R3: With `alu_fn` = 2'd2 the result is the bitwise AND of the two operands.
- R4: With `alu_fn` = 2'd3 the result is the bitwise XOR of the two operands.
- R5: `flag_zf` is 1 exactly when all 64 bits of the result are 0, whatever the function.
- R6: `flag_of` is 1 when the sum (code 0) or the difference (code 1) overflows the two's-complement range. It is always 0 for codes 2 and 3.
- R7: `flag_cf` is the carry out of bit 63 for code 0. For code 1 it is 1 when `alu_y` is larger than `alu_x` taken as unsigned numbers (a borrow). It is always 0 for codes 2 and 3.
- R8: The block holds no state. Result and flags follow any change of the inputs with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| alu_x | input | 64 | First operand word |
| alu_y | input | 64 | Second operand word (subtrahend for code 1) |
| alu_fn | input | 2 | Function selector: 0 sum, 1 difference, 2 AND, 3 XOR |
| alu_res | output | 64 | Result word |
| flag_of | output | 1 | Signed overflow flag |
| flag_zf | output | 1 | Zero-result flag |
| flag_cf | output | 1 | Carry (sum) or borrow (difference) flag |

## Verification
The embedded checks assume that every input bit holds a defined 0 or 1. They are skipped whenever any operand or selector bit is unknown. The bench drives all three inputs together, between clock edges, and always with fully defined values, so every vector it applies falls inside that assumption. The assertions relate the result back to the operands through the inverse operation, or through an unsigned comparison. They therefore hold for any defined input, and the corner operands (zero, all ones, the extreme signed values, equal operands) need no special treatment.

// File: rtl/word_alu4.sv
module word_alu4 #(
  parameter int W = 64
) (
  input  logic [W-1:0] alu_x,
  input  logic [W-1:0] alu_y,
  input  logic [1:0]   alu_fn,
  output logic [W-1:0] alu_res,
  output logic         flag_of,
  output logic         flag_zf,
  output logic         flag_cf
);
  localparam logic [1:0] FN_ADD = 2'd0;
  localparam logic [1:0] FN_SUB = 2'd1;
  localparam logic [1:0] FN_AND = 2'd2;
  localparam logic [1:0] FN_XOR = 2'd3;

  logic          is_sub;
  logic          is_arith;
  logic [W-1:0]  y_eff;
  logic [W:0]    sum_ext;
  logic          c_into_top;
  logic          c_out;

  assign is_sub   = (alu_fn == FN_SUB);
  assign is_arith = ~alu_fn[1];
  assign y_eff    = is_sub ? ~alu_y : alu_y;
  assign sum_ext  = {1'b0, alu_x} + {1'b0, y_eff} + {{W{1'b0}}, is_sub};
  assign c_out    = sum_ext[W];
  assign c_into_top = alu_x[W-1] ^ y_eff[W-1] ^ sum_ext[W-1];

  always_comb begin
    unique case (alu_fn)
      FN_AND:  alu_res = alu_x & alu_y;
      FN_XOR:  alu_res = alu_x ^ alu_y;
      default: alu_res = sum_ext[W-1:0];
    endcase
  end

  assign flag_zf = ~|alu_res;
  assign flag_of = is_arith & (c_into_top ^ c_out);
  assign flag_cf = is_arith & (c_out ^ is_sub);

  always_comb begin
    if (!$isunknown({alu_x, alu_y, alu_fn})) begin
      assert_sum_inverse_R1: assert (alu_fn != FN_ADD || alu_res - alu_y == alu_x)
        else $error("R1 sum does not invert");
      assert_diff_inverse_R2: assert (alu_fn != FN_SUB || alu_res + alu_y == alu_x)
        else $error("R2 difference does not invert");
      assert_and_subset_R3: assert (alu_fn != FN_AND || ((alu_res & ~alu_x) == '0 && (alu_res & ~alu_y) == '0))
        else $error("R3 AND result has bits outside operands");
      assert_xor_inverse_R4: assert (alu_fn != FN_XOR || (alu_res ^ alu_y) == alu_x)
        else $error("R4 XOR does not invert");
      assert_zero_flag_R5: assert (flag_zf == (alu_res == '0))
        else $error("R5 zero flag disagrees with result");
      assert_no_overflow_R6: assert (is_arith || !flag_of)
        else $error("R6 overflow set on logic function");
      assert_borrow_R7: assert (alu_fn != FN_SUB || flag_cf == (alu_x < alu_y))
        else $error("R7 borrow disagrees with unsigned compare");
      assert_carry_R7: assert (alu_fn != FN_ADD || flag_cf == (alu_res < alu_x))
        else $error("R7 carry disagrees with wraparound");
      assert_no_carry_R7: assert (is_arith || !flag_cf)
        else $error("R7 carry set on logic function");
    end
  end
endmodule

// File: tb/word_alu4_tb.sv
module word_alu4_tb;
  logic        clk = 1'b0;
  logic [63:0] x, y;
  logic [1:0]  fn;
  logic [63:0] res;
  logic        of, zf, cf;
  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  int unsigned cycles = 0;
  bit          done = 0;

  always #2.5 clk = ~clk;

  word_alu4 u_dut (
    .alu_x(x), .alu_y(y), .alu_fn(fn),
    .alu_res(res), .flag_of(of), .flag_zf(zf), .flag_cf(cf)
  );

  function automatic logic [63:0] ref_res(input logic [1:0] f, input logic [63:0] a, input logic [63:0] b);
    case (f)
      2'd0: return a + b;
      2'd1: return a - b;
      2'd2: return a & b;
      default: return a ^ b;
    endcase
  endfunction

  function automatic logic ref_of(input logic [1:0] f, input logic [63:0] a, input logic [63:0] b);
    logic signed [65:0] s;
    if (f == 2'd0) s = $signed({{2{a[63]}}, a}) + $signed({{2{b[63]}}, b});
    else if (f == 2'd1) s = $signed({{2{a[63]}}, a}) - $signed({{2{b[63]}}, b});
    else return 1'b0;
    return (s > 66'sh0_7FFF_FFFF_FFFF_FFFF) || (s < -66'sh0_8000_0000_0000_0000);
  endfunction

  function automatic logic ref_cf(input logic [1:0] f, input logic [63:0] a, input logic [63:0] b);
    logic [64:0] s;
    if (f == 2'd0) begin
      s = {1'b0, a} + {1'b0, b};
      return s[64];
    end
    if (f == 2'd1) return a < b;
    return 1'b0;
  endfunction

  task automatic cmp(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h (fn=%0d x=%h y=%h)", req, what, act, exp, fn, x, y);
    end
  endtask

  task automatic apply(input logic [1:0] f, input logic [63:0] a, input logic [63:0] b);
    logic [63:0] er;
    @(negedge clk);
    fn = f; x = a; y = b;
    #1;
    er = ref_res(f, a, b);
    case (f)
      2'd0: cmp("R1", "result", res, er);
      2'd1: cmp("R2", "result", res, er);
      2'd2: cmp("R3", "result", res, er);
      default: cmp("R4", "result", res, er);
    endcase
    cmp("R5", "zf", {63'd0, zf}, {63'd0, er == 64'd0});
    cmp("R6", "of", {63'd0, of}, {63'd0, ref_of(f, a, b)});
    cmp("R7", "cf", {63'd0, cf}, {63'd0, ref_cf(f, a, b)});
  endtask

  localparam logic [63:0] MAXP = 64'h7FFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] MINN = 64'h8000_0000_0000_0000;
  localparam logic [63:0] ONES = '1;

  initial begin
    fn = 2'd0; x = '0; y = '0;
    #1;
    cmp("R5", "idle zf", {63'd0, zf}, 64'd1);
    cmp("R1", "idle result", res, 64'd0);
    apply(2'd0, MAXP, 64'd1);
    apply(2'd0, MINN, MINN);
    apply(2'd0, ONES, 64'd1);
    apply(2'd0, 64'd0, 64'd0);
    apply(2'd1, MINN, 64'd1);
    apply(2'd1, MAXP, ONES);
    apply(2'd1, 64'd5, 64'd5);
    apply(2'd1, 64'd3, 64'd4);
    apply(2'd1, 64'd0, MINN);
    apply(2'd2, ONES, MINN);
    apply(2'd2, 64'hAAAA_AAAA_AAAA_AAAA, 64'h5555_5555_5555_5555);
    apply(2'd3, ONES, ONES);
    apply(2'd3, MAXP, MINN);
    // R8: change inputs and check again between edges, with no clock edge in between
    @(negedge clk);
    fn = 2'd0; x = 64'd10; y = 64'd20; #0.5;
    cmp("R8", "first settle", res, 64'd30);
    fn = 2'd3; x = 64'hF0; y = 64'hFF; #0.5;
    cmp("R8", "second settle", res, 64'h0F);
    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      logic [63:0] a, b;
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      if (($urandom % 8) == 0) b = a;
      if (($urandom % 8) == 1) a[63:60] = {4{a[63]}};
      apply(2'($urandom % 4), a, b);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule